// File: doc/BRIEF.md
# LCD Raster Timing Generator

This block produces the timing for a parallel RGB LCD panel. It takes its settings from plain configuration inputs: active width in blocks of 16 pixels, active height, the back porch, front porch and sync width for each axis, three polarity bits and a two-bit sync-edge control. From these it drives the panel pixel clock, a one-cycle pixel strobe, line sync, frame sync, data-enable and the current column and row. It also raises a one-cycle end-of-frame pulse, and a sync-lost pulse when the pixel source reports starvation during a visible pixel.

The block runs on a clock at twice the pixel rate. Each pixel lasts two clock cycles, and the counters advance once per pixel. Frames follow each other as long as the raster enable is high. When the enable is dropped, the current frame runs to its end and the generator then idles with its outputs quiet. All configuration inputs are captured into a shadow copy at the start of every frame, so software may rewrite them while a frame is being scanned.

Top module: `lcd_raster_timing`

## Requirements
- R1: Each pixel spans two clock cycles. `pix_ce_o` is 0 in the first cycle and 1 in the second. `pclk_o` is low in the first cycle and high in the second, and the opposite when the pixel-clock invert bit is 1.
- R2: A line is the sync segment (`h_pulse`+1 pixels), then the back porch (`h_lead`+1), then the active segment ((`width_blk`+1)*16), then the front porch (`h_tail`+1). `x_o` counts 0 upward across the active segment.
- R3: A frame is vertical sync (`v_pulse`+1 lines), then back porch (`v_lead`+1), then active lines, then front porch (`v_tail`+1). The active line count is {`rows_hi`,`rows_lo`}+1, where `rows_hi` supplies bit 10 of the 11-bit value. `y_o` counts the active lines from 0.
- R4: `de_o` is 1 only when both the horizontal and the vertical position lie in their active segments. Outside its active segment, `x_o` (and likewise `y_o`) reads 0.
- R5: With an invert bit of 0, line sync and frame sync are 1 while asserted and 0 otherwise. With an invert bit of 1, each is the complement. Frame sync stays asserted for whole lines.
- R6: When `edge_sel_en`=1 and `edge_sel_rise`=1, both syncs change one clock cycle after the data, on the rising edge of the uninverted pixel clock. Otherwise the syncs change in the same cycle as the data, on its falling edge. `edge_sel_rise` has no effect while `edge_sel_en`=0.
- R7: `eof_o` is a single-cycle pulse in the second cycle of the last pixel of the last active line.
- R8: `sync_lost_o` pulses in the second cycle of a pixel when `data_starve` is 1 and `de_o` is 1. Starvation during blanking has no effect.
- R9: Raising `raster_en` while idle starts a frame at the next pixel boundary. Frames continue back to back while it stays high. After it is cleared, the current frame completes. The block then holds `de_o`=0, `x_o`=`y_o`=0 and both syncs at their inactive levels.
- R10: Configuration inputs are captured when a frame starts. Changes made during a frame take effect only in the next frame.
- R11: While reset is held, `de_o`, `eof_o`, `sync_lost_o`, `pix_ce_o`, `x_o` and `y_o` are 0 and both syncs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the pixel rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| raster_en | input | 1 | Run the raster |
| width_blk | input | 7 | Active width in 16-pixel blocks, minus one |
| rows_lo | input | 10 | Low 10 bits of active lines minus one |
| rows_hi | input | 1 | Bit 10 of active lines minus one |
| h_lead | input | 8 | Horizontal back porch minus one |
| h_tail | input | 8 | Horizontal front porch minus one |
| h_pulse | input | 6 | Line sync width minus one |
| v_lead | input | 8 | Vertical back porch lines minus one |
| v_tail | input | 8 | Vertical front porch lines minus one |
| v_pulse | input | 6 | Frame sync width in lines minus one |
| pclk_inv | input | 1 | Invert pixel clock output |
| hsync_inv | input | 1 | Invert line sync |
| vsync_inv | input | 1 | Invert frame sync |
| edge_sel_en | input | 1 | Enable explicit sync edge choice |
| edge_sel_rise | input | 1 | Syncs change on the pixel clock rising edge |
| data_starve | input | 1 | Pixel source has no data for the current pixel |
| pclk_o | output | 1 | Panel pixel clock |
| pix_ce_o | output | 1 | Pixel strobe, high in a pixel's second cycle |
| hsync_o | output | 1 | Line sync |
| vsync_o | output | 1 | Frame sync |
| de_o | output | 1 | Data enable |
| x_o | output | 11 | Active column |
| y_o | output | 11 | Active row |
| eof_o | output | 1 | End-of-frame pulse |
| sync_lost_o | output | 1 | Starvation during a visible pixel |

## Verification
The bound checker covers the behaviours that must hold at every clock edge. These are the alternation of the pixel strobe, end-of-frame and sync-lost firing only inside visible pixels, quiet position outputs while idle, and the shadow configuration staying frozen during a running frame. The segment lengths, the sync order and polarity, the half-pixel shift of the sync edge, the split line count and the handover of new settings at the frame boundary depend on whole frames. Only the bench's scenarios show them, by comparing every cycle of complete frames against a frame model built from the requirements.

// File: rtl/lcd_rt_pkg.sv
package lcd_rt_pkg;

   // Segment of a scan axis, in scan order.
   typedef enum logic [1:0] {
      SEG_PULSE = 2'd0,
      SEG_LEAD  = 2'd1,
      SEG_SHOW  = 2'd2,
      SEG_TAIL  = 2'd3
   } seg_e;

   function automatic seg_e seg_next(input seg_e s);
      case (s)
         SEG_PULSE: return SEG_LEAD;
         SEG_LEAD:  return SEG_SHOW;
         SEG_SHOW:  return SEG_TAIL;
         default:   return SEG_PULSE;
      endcase
   endfunction

endpackage

// File: rtl/lcd_rt_seg_seq.sv
// Four-segment counter for one scan axis; every length is stored minus one.
module lcd_rt_seg_seq
   import lcd_rt_pkg::*;
#(
   parameter int CW = 11
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          step,
   input  logic [CW-1:0] len_pulse,
   input  logic [CW-1:0] len_lead,
   input  logic [CW-1:0] len_show,
   input  logic [CW-1:0] len_tail,
   output seg_e          seg,
   output logic [CW-1:0] cnt,
   output logic          at_end,
   output logic          wrap
);

   if (CW < 2) begin : g_bad_cw
      $error("lcd_rt_seg_seq: CW must be at least 2");
   end

   logic [CW-1:0] cur_len;

   always_comb begin
      case (seg)
         SEG_PULSE: cur_len = len_pulse;
         SEG_LEAD:  cur_len = len_lead;
         SEG_SHOW:  cur_len = len_show;
         default:   cur_len = len_tail;
      endcase
   end

   assign at_end = (cnt == cur_len);
   assign wrap   = at_end && (seg == SEG_TAIL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seg <= SEG_PULSE;
         cnt <= '0;
      end else if (step) begin
         if (at_end) begin
            seg <= seg_next(seg);
            cnt <= '0;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end

endmodule

// File: rtl/lcd_rt_sync_out.sv
// One sync output: optional half-pixel delay, then polarity.
module lcd_rt_sync_out (
   input  logic clk,
   input  logic rst_n,
   input  logic upd,
   input  logic raw,
   input  logic invert,
   input  logic late,
   output logic sync
);

   logic dly_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   dly_q <= 1'b0;
      else if (upd) dly_q <= raw;
   end

   assign sync = (late ? dly_q : raw) ^ invert;

endmodule

// File: rtl/lcd_raster_timing.sv
module lcd_raster_timing
   import lcd_rt_pkg::*;
#(
   parameter int BLK_W     = 7,
   parameter int UNIT_LOG2 = 4,
   parameter int ROWS_LO_W = 10,
   parameter int ROWS_HI_W = 1,
   parameter int PORCH_W   = 8,
   parameter int PULSE_W   = 6
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           raster_en,
   input  logic [BLK_W-1:0]               width_blk,
   input  logic [ROWS_LO_W-1:0]           rows_lo,
   input  logic [ROWS_HI_W-1:0]           rows_hi,
   input  logic [PORCH_W-1:0]             h_lead,
   input  logic [PORCH_W-1:0]             h_tail,
   input  logic [PULSE_W-1:0]             h_pulse,
   input  logic [PORCH_W-1:0]             v_lead,
   input  logic [PORCH_W-1:0]             v_tail,
   input  logic [PULSE_W-1:0]             v_pulse,
   input  logic                           pclk_inv,
   input  logic                           hsync_inv,
   input  logic                           vsync_inv,
   input  logic                           edge_sel_en,
   input  logic                           edge_sel_rise,
   input  logic                           data_starve,
   output logic                           pclk_o,
   output logic                           pix_ce_o,
   output logic                           hsync_o,
   output logic                           vsync_o,
   output logic                           de_o,
   output logic [BLK_W+UNIT_LOG2-1:0]     x_o,
   output logic [ROWS_LO_W+ROWS_HI_W-1:0] y_o,
   output logic                           eof_o,
   output logic                           sync_lost_o
);

   localparam int X_W    = BLK_W + UNIT_LOG2;
   localparam int ROWS_W = ROWS_LO_W + ROWS_HI_W;
   localparam int CW_A   = (X_W > ROWS_W) ? X_W : ROWS_W;
   localparam int CW     = (CW_A > PORCH_W) ? CW_A : PORCH_W;
   localparam int CFG_W  = BLK_W + ROWS_W + 4*PORCH_W + 2*PULSE_W + 5;

   if (PULSE_W > PORCH_W) begin : g_bad_pulse
      $error("lcd_raster_timing: PULSE_W must not exceed PORCH_W");
   end
   if (UNIT_LOG2 < 0 || UNIT_LOG2 > 6) begin : g_bad_unit
      $error("lcd_raster_timing: UNIT_LOG2 out of range");
   end

   // ---------------- shadow configuration ----------------
   logic [CFG_W-1:0] cfg_in, cfg_q;
   logic [BLK_W-1:0]   s_blk;
   logic [ROWS_W-1:0]  s_rows;
   logic [PORCH_W-1:0] s_hl, s_ht, s_vl, s_vt;
   logic [PULSE_W-1:0] s_hp, s_vp;
   logic s_ipc, s_ih, s_iv, s_ee, s_er;

   assign cfg_in = {width_blk, rows_hi, rows_lo, h_lead, h_tail, h_pulse,
                    v_lead, v_tail, v_pulse, pclk_inv, hsync_inv, vsync_inv,
                    edge_sel_en, edge_sel_rise};
   assign {s_blk, s_rows, s_hl, s_ht, s_hp, s_vl, s_vt, s_vp,
           s_ipc, s_ih, s_iv, s_ee, s_er} = cfg_q;

   // ---------------- pixel phase and run state ----------------
   logic ph_q, run_q;
   logic h_step, v_step, frame_end;
   logic h_end, h_wrap, v_end, v_wrap;
   seg_e h_seg, v_seg;
   logic [CW-1:0] h_cnt, v_cnt;

   assign h_step    = ph_q & run_q;
   assign v_step    = h_step & h_wrap;
   assign frame_end = v_step & v_wrap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ph_q <= 1'b0;
      else        ph_q <= ~ph_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      run_q <= 1'b0;
      else if (ph_q && !run_q)         run_q <= raster_en;
      else if (frame_end)              run_q <= raster_en;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      cfg_q <= '0;
      else if (!run_q || frame_end)    cfg_q <= cfg_in;
   end

   // ---------------- segment lengths ----------------
   logic [X_W-1:0] h_show_len;

   if (UNIT_LOG2 == 0) begin : g_unit_one
      assign h_show_len = s_blk;
   end else begin : g_unit_blk
      assign h_show_len = {s_blk, {UNIT_LOG2{1'b1}}};
   end

   lcd_rt_seg_seq #(.CW(CW)) u_hseq (
      .clk       (clk),
      .rst_n     (rst_n),
      .step      (h_step),
      .len_pulse (CW'(s_hp)),
      .len_lead  (CW'(s_hl)),
      .len_show  (CW'(h_show_len)),
      .len_tail  (CW'(s_ht)),
      .seg       (h_seg),
      .cnt       (h_cnt),
      .at_end    (h_end),
      .wrap      (h_wrap)
   );

   lcd_rt_seg_seq #(.CW(CW)) u_vseq (
      .clk       (clk),
      .rst_n     (rst_n),
      .step      (v_step),
      .len_pulse (CW'(s_vp)),
      .len_lead  (CW'(s_vl)),
      .len_show  (CW'(s_rows)),
      .len_tail  (CW'(s_vt)),
      .seg       (v_seg),
      .cnt       (v_cnt),
      .at_end    (v_end),
      .wrap      (v_wrap)
   );

   // ---------------- syncs ----------------
   logic [1:0] s_raw, s_inv, s_out;
   logic       late_edge, upd_rise;

   assign late_edge = s_ee & s_er;
   assign upd_rise  = ~ph_q;
   assign s_raw     = {run_q & (v_seg == SEG_PULSE), run_q & (h_seg == SEG_PULSE)};
   assign s_inv     = {s_iv, s_ih};

   for (genvar gi = 0; gi < 2; gi++) begin : g_sync
      lcd_rt_sync_out u_so (
         .clk    (clk),
         .rst_n  (rst_n),
         .upd    (upd_rise),
         .raw    (s_raw[gi]),
         .invert (s_inv[gi]),
         .late   (late_edge),
         .sync   (s_out[gi])
      );
   end

   assign hsync_o = s_out[0];
   assign vsync_o = s_out[1];

   // ---------------- data-side outputs ----------------
   logic h_vis, v_vis;

   assign h_vis       = run_q && (h_seg == SEG_SHOW);
   assign v_vis       = run_q && (v_seg == SEG_SHOW);
   assign de_o        = h_vis & v_vis;
   assign x_o         = h_vis ? h_cnt[X_W-1:0] : '0;
   assign y_o         = v_vis ? v_cnt[ROWS_W-1:0] : '0;
   assign pix_ce_o    = ph_q;
   assign pclk_o      = ph_q ^ s_ipc;
   assign eof_o       = ph_q & de_o & h_end & v_end;
   assign sync_lost_o = ph_q & de_o & data_starve;

endmodule

// File: rtl/lcd_raster_timing_chk.sv
module lcd_raster_timing_chk #(
   parameter int CFG_W = 64,
   parameter int XW    = 11,
   parameter int YW    = 11
) (
   input logic             clk,
   input logic             rst_n,
   input logic             pix_ce,
   input logic             de,
   input logic [XW-1:0]    x_pos,
   input logic [YW-1:0]    y_pos,
   input logic             eof,
   input logic             sync_lost,
   input logic             starve,
   input logic             running,
   input logic             frame_end,
   input logic [CFG_W-1:0] cfg
);

   p_ce_drop_r1: assert property (@(posedge clk) disable iff (!rst_n)
      pix_ce |=> !pix_ce);

   p_ce_rise_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !pix_ce |=> pix_ce);

   p_eof_visible_r7: assert property (@(posedge clk) disable iff (!rst_n)
      eof |-> (de && pix_ce));

   p_lost_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
      sync_lost |-> (de && pix_ce && starve));

   p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !running |-> (!de && x_pos == '0 && y_pos == '0));

   p_cfg_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (running && !frame_end) |=> $stable(cfg));

endmodule

bind lcd_raster_timing lcd_raster_timing_chk #(
   .CFG_W (CFG_W),
   .XW    (X_W),
   .YW    (ROWS_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .pix_ce    (pix_ce_o),
   .de        (de_o),
   .x_pos     (x_o),
   .y_pos     (y_o),
   .eof       (eof_o),
   .sync_lost (sync_lost_o),
   .starve    (data_starve),
   .running   (run_q),
   .frame_end (frame_end),
   .cfg       (cfg_q)
);

// File: tb/lcd_raster_timing_bench.sv
module lcd_raster_timing_bench;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic        raster_en = 1'b0;
   logic [6:0]  width_blk = '0;
   logic [9:0]  rows_lo = '0;
   logic [0:0]  rows_hi = '0;
   logic [7:0]  h_lead = '0, h_tail = '0, v_lead = '0, v_tail = '0;
   logic [5:0]  h_pulse = '0, v_pulse = '0;
   logic        pclk_inv = 1'b0, hsync_inv = 1'b0, vsync_inv = 1'b0;
   logic        edge_sel_en = 1'b0, edge_sel_rise = 1'b0, data_starve = 1'b0;
   logic        pclk_o, pix_ce_o, hsync_o, vsync_o, de_o, eof_o, sync_lost_o;
   logic [10:0] x_o, y_o;

   lcd_raster_timing u_lcd_raster_timing (
      .clk(clk), .rst_n(rst_n), .raster_en(raster_en),
      .width_blk(width_blk), .rows_lo(rows_lo), .rows_hi(rows_hi),
      .h_lead(h_lead), .h_tail(h_tail), .h_pulse(h_pulse),
      .v_lead(v_lead), .v_tail(v_tail), .v_pulse(v_pulse),
      .pclk_inv(pclk_inv), .hsync_inv(hsync_inv), .vsync_inv(vsync_inv),
      .edge_sel_en(edge_sel_en), .edge_sel_rise(edge_sel_rise),
      .data_starve(data_starve),
      .pclk_o(pclk_o), .pix_ce_o(pix_ce_o), .hsync_o(hsync_o),
      .vsync_o(vsync_o), .de_o(de_o), .x_o(x_o), .y_o(y_o),
      .eof_o(eof_o), .sync_lost_o(sync_lost_o)
   );

   int n_chk = 0;
   int n_bad = 0;

   typedef struct {
      int blk; int rows;
      int hp; int hl; int ht;
      int vp; int vl; int vt;
      bit ipc; bit ih; bit iv; bit ee; bit er;
   } cfg_t;

   cfg_t cur;

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic put_cfg(input cfg_t c);
      cur = c;
      width_blk = 7'(c.blk);
      rows_lo = c.rows[9:0];
      rows_hi = c.rows[10];
      h_pulse = 6'(c.hp); h_lead = 8'(c.hl); h_tail = 8'(c.ht);
      v_pulse = 6'(c.vp); v_lead = 8'(c.vl); v_tail = 8'(c.vt);
      pclk_inv = c.ipc; hsync_inv = c.ih; vsync_inv = c.iv;
      edge_sel_en = c.ee; edge_sel_rise = c.er;
   endtask

   function automatic int line_len(input cfg_t c);
      return (c.hp + 1) + (c.hl + 1) + (c.blk + 1) * 16 + (c.ht + 1);
   endfunction

   function automatic int frame_len(input cfg_t c);
      return line_len(c) * ((c.vp + 1) + (c.vl + 1) + (c.rows + 1) + (c.vt + 1));
   endfunction

   // Frame model from the requirements (R2, R3, R4, R7).
   function automatic void model(input cfg_t c, input int p, output int hs, output int vs,
                                 output int de, output int x, output int y, output int lastpx);
      int h, v, h0, v0, ha, va;
      bit hact, vact;
      h  = p % line_len(c);
      v  = p / line_len(c);
      h0 = (c.hp + 1) + (c.hl + 1);
      v0 = (c.vp + 1) + (c.vl + 1);
      ha = (c.blk + 1) * 16;
      va = c.rows + 1;
      hs = (h < c.hp + 1) ? 1 : 0;
      vs = (v < c.vp + 1) ? 1 : 0;
      hact = (h >= h0) && (h < h0 + ha);
      vact = (v >= v0) && (v < v0 + va);
      x  = hact ? h - h0 : 0;
      y  = vact ? v - v0 : 0;
      de = (hact && vact) ? 1 : 0;
      lastpx = (hact && vact && h == h0 + ha - 1 && v == v0 + va - 1) ? 1 : 0;
   endfunction

   task automatic check_pixel(input string scn, input cfg_t c, input int p, input bit starve);
      int hs, vs, de, x, y, lp, phs, pvs, pde, px, py, plp;
      bit late;
      string rs;
      late = c.ee && c.er;
      rs = late ? "R6" : "R5";
      model(c, p, hs, vs, de, x, y, lp);
      if (p == 0) begin phs = 0; pvs = 0; end
      else model(c, p - 1, phs, pvs, pde, px, py, plp);
      // first cycle of the pixel
      @(negedge clk);
      chk({scn, " R1"}, "pix_ce A", int'(pix_ce_o), 0);
      chk({scn, " R1"}, "pclk A", int'(pclk_o), int'(c.ipc));
      chk({scn, " ", rs}, "hsync A", int'(hsync_o), (late ? phs : hs) ^ int'(c.ih));
      chk({scn, " ", rs}, "vsync A", int'(vsync_o), (late ? pvs : vs) ^ int'(c.iv));
      chk({scn, " R4"}, "de A", int'(de_o), de);
      chk({scn, " R2"}, "x A", int'(x_o), x);
      chk({scn, " R3"}, "y A", int'(y_o), y);
      chk({scn, " R7"}, "eof A", int'(eof_o), 0);
      chk({scn, " R8"}, "lost A", int'(sync_lost_o), 0);
      // second cycle of the pixel
      @(negedge clk);
      chk({scn, " R1"}, "pix_ce B", int'(pix_ce_o), 1);
      chk({scn, " R1"}, "pclk B", int'(pclk_o), int'(!c.ipc));
      chk({scn, " ", rs}, "hsync B", int'(hsync_o), hs ^ int'(c.ih));
      chk({scn, " ", rs}, "vsync B", int'(vsync_o), vs ^ int'(c.iv));
      chk({scn, " R4"}, "de B", int'(de_o), de);
      chk({scn, " R7"}, "eof B", int'(eof_o), lp);
      chk({scn, " R8"}, "lost B", int'(sync_lost_o), starve ? de : 0);
   endtask

   // R9: raise the enable; the frame starts at the next pixel boundary.
   task automatic start_raster();
      @(negedge clk);
      raster_en = 1'b1;
      if (!pix_ce_o) @(negedge clk);
   endtask

   task automatic run_frames(input string scn, input int nf, input int stop_at,
                             input int chg_at, input cfg_t nxt);
      cfg_t fc;
      fc = cur;
      for (int f = 0; f < nf; f++) begin
         for (int p = 0; p < frame_len(fc); p++) begin
            check_pixel(scn, fc, p, data_starve);
            if (f == nf - 1 && p == stop_at) raster_en = 1'b0;
            if (f == 0 && p == chg_at) put_cfg(nxt);
         end
         fc = cur;
      end
   endtask

   // R9: after the frame in which the enable fell, everything stays quiet.
   task automatic check_idle(input string scn, input int ncyc);
      for (int i = 0; i < ncyc; i++) begin
         @(negedge clk);
         chk({scn, " R9"}, "idle de", int'(de_o), 0);
         chk({scn, " R9"}, "idle x", int'(x_o), 0);
         chk({scn, " R9"}, "idle y", int'(y_o), 0);
         chk({scn, " R9"}, "idle hsync", int'(hsync_o), int'(cur.ih));
         chk({scn, " R9"}, "idle vsync", int'(vsync_o), int'(cur.iv));
         chk({scn, " R9"}, "idle eof", int'(eof_o), 0);
      end
   endtask

   cfg_t cfg_a, cfg_b, cfg_c, cfg_d, cfg_e;

   task automatic t_reset();
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         chk("R11", "rst de", int'(de_o), 0);
         chk("R11", "rst hsync", int'(hsync_o), 0);
         chk("R11", "rst vsync", int'(vsync_o), 0);
         chk("R11", "rst x", int'(x_o), 0);
         chk("R11", "rst y", int'(y_o), 0);
         chk("R11", "rst eof", int'(eof_o), 0);
         chk("R11", "rst lost", int'(sync_lost_o), 0);
         chk("R11", "rst pix_ce", int'(pix_ce_o), 0);
      end
      rst_n = 1'b1;
   endtask

   task automatic t_basic();
      put_cfg(cfg_a);
      data_starve = 1'b0;
      start_raster();
      run_frames("basic", 2, 5, -1, cfg_a);
      check_idle("basic", 30);
   endtask

   task automatic t_late_inverted();
      put_cfg(cfg_b);
      data_starve = 1'b1;
      start_raster();
      run_frames("late", 1, 0, -1, cfg_b);
      check_idle("late", 20);
      data_starve = 1'b0;
   endtask

   task automatic t_rise_ignored();
      put_cfg(cfg_c);
      start_raster();
      run_frames("rise_off R6", 1, 3, -1, cfg_c);
      check_idle("rise_off", 10);
   endtask

   task automatic t_midframe_change();
      put_cfg(cfg_a);
      start_raster();
      run_frames("R10 midframe", 2, 0, 10, cfg_d);
      check_idle("R10 midframe", 10);
   endtask

   task automatic t_tall();
      put_cfg(cfg_e);
      start_raster();
      run_frames("R3 tall", 1, 0, -1, cfg_e);
      check_idle("tall", 10);
   endtask

   initial begin
      cfg_a = '{blk:0, rows:1, hp:1, hl:0, ht:2, vp:0, vl:1, vt:0,
                ipc:0, ih:0, iv:0, ee:0, er:0};
      cfg_b = '{blk:1, rows:2, hp:0, hl:1, ht:0, vp:1, vl:0, vt:1,
                ipc:1, ih:1, iv:1, ee:1, er:1};
      cfg_c = '{blk:0, rows:1, hp:1, hl:0, ht:2, vp:0, vl:1, vt:0,
                ipc:0, ih:0, iv:1, ee:0, er:1};
      cfg_d = '{blk:0, rows:3, hp:2, hl:1, ht:0, vp:1, vl:0, vt:0,
                ipc:1, ih:1, iv:0, ee:0, er:0};
      cfg_e = '{blk:0, rows:1024, hp:0, hl:0, ht:0, vp:0, vl:0, vt:0,
                ipc:0, ih:0, iv:0, ee:0, er:0};
      t_reset();
      t_basic();
      t_late_inverted();
      t_rise_ignored();
      t_midframe_change();
      t_tall();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule